// File: doc/BRIEF.md
# Dual-Channel Interval Timer

This peripheral holds one or two independent 32-bit timer channels behind a plain word-wide register port. Each channel has a control word, a load value and a live counter. Software writes the load value and then a control word with the run bit set. The counter is preloaded and then moves one step every clock cycle, either down towards zero or up towards all-ones. When it reaches that end value, the channel raises a sticky flag. It then either preloads again and keeps going, or halts.

The flags of all channels, each gated by its own interrupt enable, are OR-ed onto a single interrupt output. Software clears a flag by writing a control word that has the flag bit set. A parameter removes the second channel. Reads are combinational on the address, and writes take effect at the clock edge.

Top module: `interval_timer`

## Requirements
- R1: The word address is split into a slot field and a channel field. The slot field is address bits [1:0]: slot 0 is the control word, slot 1 the load value, slot 2 the counter and slot 3 reserved. The channel field is the address bits above the slot field. The reserved slot reads zero and ignores writes. Writes to the counter slot are ignored. An address whose channel field names a channel that does not exist reads zero.
- R2: The interrupt output is high exactly when at least one channel has both its flag (control bit 8) and its interrupt enable (control bit 6) set.
- R3: A control write keeps only bits [10:0] of the written word, and control bits 31..11 always read zero. The control bits are: 0 mode, 1 count-down, 2 generate, 3 capture, 4 auto-reload, 5 load, 6 interrupt enable, 7 run, 8 flag, 9 pwm, 10 enable-all. Bits 0, 2, 3, 5, 9 and 10 are only stored.
- R4: A control write with bit 8 set clears the flag. A control write with bit 8 clear leaves the flag unchanged.
- R5: A control write with bit 7 set copies the load value into the counter at that edge and starts the channel.
- R6: While the channel runs, the counter decrements once per clock when bit 1 is set and increments once per clock when bit 1 is clear.
- R7: A running channel expires on the edge where its counter is at its end value. The end value is 0 when counting down and 0xFFFFFFFF when counting up. On that edge the flag is set. With bit 4 set, the counter is preloaded from the load value and the channel keeps running. A control write in the same cycle takes precedence, and no expiry occurs.
- R8: On expiry with bit 4 clear, bit 7 clears and the counter holds its end value.
- R9: A control write with bit 7 clear stops the channel, and the counter keeps its current value.
- R10: Synchronous reset clears every register of every channel, and the interrupt output is low in the cycle after reset.
- R11: The load value reads back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe for the word at addr |
| addr | input | ADDR_W | Word address: slot in bits [1:0], channel above |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for addr (combinational) |
| irq | output | 1 | Shared interrupt output |

## Verification
The assertions assume that wrEn and addr are clean and stable for a whole cycle. They also assume that each write targets exactly one slot of one channel, so a load write and a control write never reach the same channel in the same cycle. The bench changes its inputs only just after a rising edge and issues one write at a time. It lets both channels run together, so their expiries overlap on the shared interrupt. It also places a control write on the exact cycle a counter sits at its end value, to test the write-over-expiry priority.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_W = 11;

  localparam int B_MODE = 0;
  localparam int B_DOWN = 1;
  localparam int B_GEN  = 2;
  localparam int B_CAP  = 3;
  localparam int B_AUTO = 4;
  localparam int B_LDB  = 5;
  localparam int B_IE   = 6;
  localparam int B_RUN  = 7;
  localparam int B_FLAG = 8;
  localparam int B_PWM  = 9;
  localparam int B_ALL  = 10;

  localparam logic [1:0] SLOT_CTRL = 2'd0;
  localparam logic [1:0] SLOT_LOAD = 2'd1;
  localparam logic [1:0] SLOT_CNT  = 2'd2;

  typedef struct packed {
    logic reload;
    logic step;
    logic countDown;
  } cnt_cmd_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrCtrl,
  input  logic [CTRL_W-1:0] wrBits,
  input  logic              atTerm,
  output logic [CTRL_W-1:0] ctrlWord,
  output cnt_cmd_t          cmd,
  output logic              irqReq
);
  logic [CTRL_W-1:0] ctrlQ;
  logic [CTRL_W-1:0] ctrlNext;
  logic              expire;

  assign expire = ctrlQ[B_RUN] && atTerm && !wrCtrl;

  always_comb begin
    cmd.reload    = (wrCtrl && wrBits[B_RUN]) || (expire && ctrlQ[B_AUTO]);
    cmd.step      = ctrlQ[B_RUN] && !atTerm && !wrCtrl;
    cmd.countDown = ctrlQ[B_DOWN];
  end

  always_comb begin
    ctrlNext = ctrlQ;
    if (wrCtrl) begin
      ctrlNext         = wrBits;
      ctrlNext[B_FLAG] = ctrlQ[B_FLAG] & ~wrBits[B_FLAG];
    end else if (expire) begin
      ctrlNext[B_FLAG] = 1'b1;
      if (!ctrlQ[B_AUTO]) ctrlNext[B_RUN] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctrlQ <= '0;
    else     ctrlQ <= ctrlNext;
  end

  assign ctrlWord = ctrlQ;
  assign irqReq   = ctrlQ[B_FLAG] & ctrlQ[B_IE];

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    wrCtrl && wrBits[B_FLAG] |=> !ctrlQ[B_FLAG]); // R4
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
    wrCtrl && !wrBits[B_FLAG] && ctrlQ[B_FLAG] |=> ctrlQ[B_FLAG]); // R4
  AST_EXPIRE_FLAG: assert property (@(posedge clk) disable iff (rst)
    ctrlQ[B_RUN] && atTerm && !wrCtrl |=> ctrlQ[B_FLAG]); // R7
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
    ctrlQ[B_RUN] && atTerm && !wrCtrl && !ctrlQ[B_AUTO] |=> !ctrlQ[B_RUN]); // R8
  AST_AUTO_RUNS: assert property (@(posedge clk) disable iff (rst)
    ctrlQ[B_RUN] && atTerm && !wrCtrl && ctrlQ[B_AUTO] |=> ctrlQ[B_RUN]); // R7
endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrLoad,
  input  logic [DATA_W-1:0] wrData,
  input  cnt_cmd_t          cmd,
  output logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] countVal,
  output logic              atTerm
);
  logic [DATA_W-1:0] loadQ;
  logic [DATA_W-1:0] countQ;
  logic [DATA_W-1:0] stepped;

  assign stepped = cmd.countDown ? countQ - DATA_W'(1) : countQ + DATA_W'(1);
  assign atTerm  = cmd.countDown ? (countQ == '0) : (countQ == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      loadQ  <= '0;
      countQ <= '0;
    end else begin
      if (wrLoad) loadQ <= wrData;
      if (cmd.reload)    countQ <= loadQ;
      else if (cmd.step) countQ <= stepped;
    end
  end

  assign loadVal  = loadQ;
  assign countVal = countQ;

  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    cmd.reload |=> countQ == $past(loadQ)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cmd.reload && !cmd.step |=> $stable(countQ)); // R9
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    cmd.step && cmd.countDown |=> countQ == $past(countQ) - DATA_W'(1)); // R6
  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    cmd.step && !cmd.countDown |=> countQ == $past(countQ) + DATA_W'(1)); // R6
  AST_LOAD_KEPT: assert property (@(posedge clk) disable iff (rst)
    !wrLoad |=> $stable(loadQ)); // R11
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import tmr_pkg::*;
#(
  parameter bit SINGLE_TIMER = 1'b0,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  localparam int NUM_CH = SINGLE_TIMER ? 1 : 2;
  localparam int CH_AW  = ADDR_W - 2;

  logic [1:0]       slot;
  logic [CH_AW-1:0] chIdx;
  assign slot  = addr[1:0];
  assign chIdx = addr[ADDR_W-1:2];

  logic [CTRL_W-1:0] ctrlArr  [NUM_CH];
  logic [DATA_W-1:0] loadArr  [NUM_CH];
  logic [DATA_W-1:0] countArr [NUM_CH];
  logic [NUM_CH-1:0] irqVec;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cnt_cmd_t cmd;
    logic     atTerm;
    logic     hit;
    assign hit = wrEn && (chIdx == CH_AW'(c));

    tmr_ctrl u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .wrCtrl   (hit && slot == SLOT_CTRL),
      .wrBits   (wrData[CTRL_W-1:0]),
      .atTerm   (atTerm),
      .ctrlWord (ctrlArr[c]),
      .cmd      (cmd),
      .irqReq   (irqVec[c])
    );

    tmr_dp #(.DATA_W(DATA_W)) u_dp (
      .clk      (clk),
      .rst      (rst),
      .wrLoad   (hit && slot == SLOT_LOAD),
      .wrData   (wrData),
      .cmd      (cmd),
      .loadVal  (loadArr[c]),
      .countVal (countArr[c]),
      .atTerm   (atTerm)
    );
  end

  always_comb begin
    rdData = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (chIdx == CH_AW'(c)) begin
        case (slot)
          SLOT_CTRL: rdData = DATA_W'(ctrlArr[c]);
          SLOT_LOAD: rdData = loadArr[c];
          SLOT_CNT:  rdData = countArr[c];
          default:   rdData = '0;
        endcase
      end
    end
  end

  assign irq = |irqVec;

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !irq); // R10
endmodule

// File: tb/tb_interval_timer.sv
`timescale 1ns/100ps
module tb_interval_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  interval_timer dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // behavioural reference model
  logic [10:0] mCtrl [2];
  bit          mFlag [2];
  logic [31:0] mLoad [2];
  logic [31:0] mCnt  [2];

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        mCtrl[c] = '0; mFlag[c] = 0; mLoad[c] = '0; mCnt[c] = '0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        automatic bit sel  = (int'(addr[2]) == c);
        automatic bit wc   = wrEn && sel && (addr[1:0] == 2'd0);
        automatic bit wl   = wrEn && sel && (addr[1:0] == 2'd1);
        automatic bit term = mCtrl[c][1] ? (mCnt[c] == 0) : (mCnt[c] == 32'hFFFF_FFFF);
        if (wc) begin
          mFlag[c] = mFlag[c] && !wrData[8];
          mCtrl[c] = wrData[10:0];
          if (wrData[7]) mCnt[c] = mLoad[c];
        end else if (mCtrl[c][7]) begin
          if (term) begin
            mFlag[c] = 1;
            if (mCtrl[c][4]) mCnt[c] = mLoad[c];
            else mCtrl[c][7] = 1'b0;
          end else begin
            mCnt[c] = mCtrl[c][1] ? mCnt[c] - 1 : mCnt[c] + 1;
          end
        end
        if (wl) mLoad[c] = wrData;
      end
    end
  end

  function automatic logic [31:0] modelRead(logic [2:0] a);
    automatic int c = a[2];
    case (a[1:0])
      2'd0: return {21'b0, mCtrl[c][10:9], mFlag[c], mCtrl[c][7:0]};
      2'd1: return mLoad[c];
      2'd2: return mCnt[c];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic modelIrq();
    return (mFlag[0] && mCtrl[0][6]) || (mFlag[1] && mCtrl[1][6]);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    chk("R2 irq lockstep", {31'b0, irq}, {31'b0, modelIrq()});
    chk("R1 read lockstep", rdData, modelRead(addr));
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wrReg(logic [2:0] a, logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic readReg(logic [2:0] a, logic [31:0] exp, string tag);
    addr = a;
    #0.5;
    chk(tag, rdData, exp);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    for (int a = 0; a < 8; a++) readReg(3'(a), 32'h0, "R10 reset value");
    chk("R10 irq after reset", {31'b0, irq}, 32'h0);

    // one-shot down count on channel 0
    wrReg(3'd1, 32'd5);
    readReg(3'd1, 32'd5, "R11 load readback");
    wrReg(3'd0, 32'h0C2);
    readReg(3'd2, 32'd5, "R5 preload on start");
    ticks(3);
    readReg(3'd2, 32'd2, "R6 down count");
    ticks(2);
    chk("R7 no flag before expiry", {31'b0, irq}, 32'h0);
    tick();
    readReg(3'd0, 32'h142, "R8 run bit cleared, flag set");
    chk("R2 irq on flag", {31'b0, irq}, 32'h1);
    ticks(2);
    readReg(3'd2, 32'h0, "R8 counter holds end value");
    wrReg(3'd0, 32'h100);
    readReg(3'd0, 32'h0, "R4 flag cleared");
    chk("R4 irq dropped", {31'b0, irq}, 32'h0);

    // auto-reload up count on channel 1
    wrReg(3'd5, 32'hFFFF_FFFC);
    wrReg(3'd4, 32'h0D0);
    ticks(3);
    readReg(3'd6, 32'hFFFF_FFFF, "R6 up count");
    tick();
    readReg(3'd6, 32'hFFFF_FFFC, "R7 reload on expiry");
    readReg(3'd4, 32'h1D0, "R7 still running with flag");
    chk("R2 irq from channel 1", {31'b0, irq}, 32'h1);
    ticks(2);
    readReg(3'd6, 32'hFFFF_FFFE, "R7 keeps counting");

    // stop by control write
    wrReg(3'd4, 32'h150);
    readReg(3'd6, 32'hFFFF_FFFE, "R9 stop");
    ticks(3);
    readReg(3'd6, 32'hFFFF_FFFE, "R9 counter holds");
    readReg(3'd4, 32'h050, "R4 flag cleared by write");

    // map corners
    wrReg(3'd3, 32'hDEAD_BEEF);
    readReg(3'd3, 32'h0, "R1 reserved slot");
    wrReg(3'd2, 32'h1234_5678);
    readReg(3'd2, 32'h0, "R1 counter write ignored");
    wrReg(3'd0, 32'hFFFF_F804);
    readReg(3'd0, 32'h004, "R3 upper bits dropped");

    // flag without interrupt enable
    wrReg(3'd1, 32'd1);
    wrReg(3'd0, 32'h082);
    ticks(2);
    readReg(3'd0, 32'h102, "R2 flag set, enable off");
    chk("R2 irq gated", {31'b0, irq}, 32'h0);
    wrReg(3'd0, 32'h042);
    readReg(3'd0, 32'h142, "R4 flag kept");
    chk("R2 irq after enable", {31'b0, irq}, 32'h1);

    // control write on the terminal cycle wins
    wrReg(3'd1, 32'd2);
    wrReg(3'd0, 32'h182);
    ticks(2);
    readReg(3'd2, 32'h0, "R6 reached zero");
    wrReg(3'd0, 32'h082);
    readReg(3'd0, 32'h082, "R7 write priority, no flag");
    readReg(3'd2, 32'd2, "R5 preload on rewrite");

    // both channels free-running
    wrReg(3'd1, 32'd3);
    wrReg(3'd5, 32'hFFFF_FFF0);
    wrReg(3'd0, 32'h1D2);
    wrReg(3'd4, 32'h1D0);
    ticks(40);

    // reset mid-run
    rst = 1'b1;
    tick();
    rst = 1'b0;
    for (int a = 0; a < 8; a++) readReg(3'(a), 32'h0, "R10 mid-run reset");
    chk("R10 irq low", {31'b0, irq}, 32'h0);
    ticks(2);

    done = 1'b1;
    finishRun();
  end
endmodule